// File: doc/BRIEF.md
# Queued SPI master controller

This block is an SPI master that works through a short queue of byte transfers without processor help. Three small memories sit behind one pointer register and one data port: transmit bytes, receive bytes and per-entry command words. Software fills the transmit and command entries through the data port. It sets the last entry index and the chip-select idle level, then writes the start bit. The sequencer shifts every entry from index 0 up to the last index out on SCK/MOSI and samples MISO. It stores each received byte at the same index and then raises a finished flag. Software clears that flag by writing a 1 to it.

Software sets the clock polarity, the clock phase and a divider. Each SCK half period lasts that many system clocks, with a minimum of 2. The command word of each entry decides whether chip select stays asserted into the next entry. If it does not stay asserted, chip select returns to idle for one full SCK period before the next entry.

The sequencer is a five-state machine:
- IDLE goes to LEAD on a start request.
- LEAD waits one half period with chip select asserted, then goes to SHIFT.
- SHIFT makes the 16 clock edges of a byte and then goes to TRAIL.
- TRAIL waits one half period and writes the received byte. From TRAIL, the last entry returns to IDLE, a continuous entry goes to LEAD, and any other entry goes to GAP.
- GAP holds chip select idle for two half periods and then goes to LEAD.

Top module: `spi_queue_master`

## Requirements
- R1: After reset: `cs_o` is 1 (idle level high), `sck_oe` and `mosi_oe` are 0, and the control, flag, wrap, mode and pointer registers read 0, except wrap bit 8, which reads 1.
- R2: The register addresses are mode 0, control 1, wrap 2, flag 3, pointer 4 and data 5. In the pointer register, bits [9:8] select the region (0 = transmit, 1 = receive, 2 = command) and bits [3:0] hold the index. Each data-port write or read steps the index by one, wrapping from 15 to 0. Transmit bytes and command words read back as written.
- R3: Wrap bits [3:0] hold the last entry index. A started queue transfers entries 0 through that index and places the byte received for entry k at receive index k.
- R4: Mode bit 9 is CPOL and bit 8 is CPHA. Data are shifted MSB first. With CPHA 0, MOSI is valid before the first edge and MISO is sampled on the leading edge. With CPHA 1, MOSI changes on the leading edge and MISO is sampled on the trailing edge. SCK rests at CPOL between transfers.
- R5: Mode bits [7:0] hold the divider. Each SCK half period lasts max(2, divider) system clocks.
- R6: Mode bit 10 enables master operation. `sck_oe` and `mosi_oe` follow it, and a start request made while it is 0 is ignored.
- R7: Flag bit 0 is set when the last entry completes. Writing 1 to it clears it, and writing 0 leaves it set.
- R8: Writing 1 to control bit 0 starts the queue. Control bit 0 reads 1 while the queue runs and returns to 0 by itself when the finished flag is set.
- R9: Wrap bit 8 sets the level of `cs_o` while no entry is active. `cs_o` takes the opposite level while an entry is active.
- R10: If command bit 0 of an entry is 1, chip select stays asserted into the next entry. If it is 0, chip select goes idle for at least 2×max(2, divider) system clocks before the next entry. Command bit 1 is stored and read back but has no effect at 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (advances the data-port index) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 11 | Write data |
| bus_rdata | output | 11 | Read data, combinational from the address |
| sck_o | output | 1 | Serial clock |
| sck_oe | output | 1 | Serial clock drive enable |
| mosi_o | output | 1 | Serial data out |
| mosi_oe | output | 1 | Serial data out drive enable |
| miso_i | input | 1 | Serial data in |
| cs_o | output | 1 | Chip select |

## Verification
A loopback slave model in the bench replies with computed bytes and captures MOSI. The bench runs 16-entry and 1-entry queues in all four clock modes.
- If a design sampled on the wrong edge or shifted LSB first, its receive bytes would come out off by one bit or bit-reversed.
- If a design lost the byte at an entry boundary, its receive bytes would land at the wrong index.
- Divider fields 0 and 1 check the clamp to 2. A design without the clamp would produce an SCK half period shorter than 2 system clocks.
- The bench mixes continuous and non-continuous entries and counts chip-select releases and their widths. This exposes a design that ignored the continuous bit or shortened the gap.
- The bench also writes 0 and then 1 to the finished flag, and requests a start with master mode off. A wrong design would clear the flag on the 0 write, or run the queue without master mode.

// File: rtl/spiq_pkg.sv
package spiq_pkg;
    localparam int REG_W = 11;

    localparam logic [2:0] A_MODE = 3'd0;
    localparam logic [2:0] A_CTRL = 3'd1;
    localparam logic [2:0] A_WRAP = 3'd2;
    localparam logic [2:0] A_FLAG = 3'd3;
    localparam logic [2:0] A_PTR  = 3'd4;
    localparam logic [2:0] A_DATA = 3'd5;

    localparam logic [1:0] RG_TX  = 2'd0;
    localparam logic [1:0] RG_RX  = 2'd1;
    localparam logic [1:0] RG_CMD = 2'd2;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_LEAD,
        SQ_SHIFT,
        SQ_TRAIL,
        SQ_GAP
    } sq_state_t;
endpackage

// File: rtl/spiq_regs.sv
module spiq_regs
    import spiq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [2:0]        bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic [7:0]        div,
    output logic              cpha,
    output logic              cpol,
    output logic              mstr,
    output logic [AW-1:0]     endp,
    output logic              cs_idle,
    output logic              start,
    input  logic              busy,
    input  logic              done_set,
    input  logic [AW-1:0]     fetch_idx,
    output logic [DW-1:0]     fetch_tx,
    input  logic [AW-1:0]     cur_idx,
    output logic              cur_cont,
    input  logic              rx_we,
    input  logic [DW-1:0]     rx_data
);
    logic [10:0]   mode_q;
    logic [AW-1:0] endp_q, ptr_q;
    logic          idle_q, done_q;
    logic [1:0]    region_q;
    logic [DW-1:0] tx_mem [DEPTH];
    logic [DW-1:0] rx_mem [DEPTH];
    logic [1:0]    cmd_mem [DEPTH];

    wire data_wr  = bus_wr && bus_addr == A_DATA;
    wire data_rd  = bus_rd && bus_addr == A_DATA;
    wire flag_clr = bus_wr && bus_addr == A_FLAG && bus_wdata[0];

    assign div     = mode_q[7:0];
    assign cpha    = mode_q[8];
    assign cpol    = mode_q[9];
    assign mstr    = mode_q[10];
    assign endp    = endp_q;
    assign cs_idle = idle_q;
    assign start   = bus_wr && bus_addr == A_CTRL && bus_wdata[0] && mstr && !busy;
    assign fetch_tx = tx_mem[fetch_idx];
    assign cur_cont = cmd_mem[cur_idx][0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= '0;
            endp_q   <= '0;
            idle_q   <= 1'b1;
            done_q   <= 1'b0;
            region_q <= RG_TX;
            ptr_q    <= '0;
        end else begin
            if (done_set)      done_q <= 1'b1;
            else if (flag_clr) done_q <= 1'b0;
            if (bus_wr) begin
                case (bus_addr)
                    A_MODE: mode_q <= bus_wdata[10:0];
                    A_WRAP: begin
                        endp_q <= bus_wdata[AW-1:0];
                        idle_q <= bus_wdata[8];
                    end
                    A_PTR: begin
                        region_q <= bus_wdata[9:8];
                        ptr_q    <= bus_wdata[AW-1:0];
                    end
                    default: ;
                endcase
            end
            if (data_wr || data_rd) ptr_q <= ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (data_wr && region_q == RG_TX)  tx_mem[ptr_q]  <= bus_wdata[DW-1:0];
        if (data_wr && region_q == RG_CMD) cmd_mem[ptr_q] <= bus_wdata[1:0];
        if (rx_we)
            rx_mem[cur_idx] <= rx_data;
        else if (data_wr && region_q == RG_RX)
            rx_mem[ptr_q] <= bus_wdata[DW-1:0];
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_MODE: bus_rdata = mode_q;
            A_CTRL: bus_rdata[0] = busy;
            A_WRAP: begin
                bus_rdata[AW-1:0] = endp_q;
                bus_rdata[8]      = idle_q;
            end
            A_FLAG: bus_rdata[0] = done_q;
            A_PTR: begin
                bus_rdata[AW-1:0] = ptr_q;
                bus_rdata[9:8]    = region_q;
            end
            A_DATA: begin
                case (region_q)
                    RG_TX:   bus_rdata[DW-1:0] = tx_mem[ptr_q];
                    RG_RX:   bus_rdata[DW-1:0] = rx_mem[ptr_q];
                    RG_CMD:  bus_rdata[1:0]    = cmd_mem[ptr_q];
                    default: ;
                endcase
            end
            default: ;
        endcase
    end

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> !busy);                                   // R8
    AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> mstr);                                            // R6
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !flag_clr) |=> done_q);                          // R7
endmodule

// File: rtl/spiq_seq.sv
module spiq_seq
    import spiq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int DIVW  = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int EW   = $clog2(2*DW),
    localparam int CW   = DIVW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DIVW-1:0] div,
    input  logic          cpha,
    input  logic [AW-1:0] endp,
    input  logic [DW-1:0] fetch_tx,
    input  logic          cur_cont,
    input  logic          miso,
    output logic [AW-1:0] fetch_idx,
    output logic [AW-1:0] idx,
    output logic          rx_we,
    output logic [DW-1:0] rx_data,
    output logic          busy,
    output logic          done_set,
    output logic          sck_ph,
    output logic          mosi,
    output logic          cs_act
);
    localparam logic [EW-1:0] LAST_EDGE = EW'(2*DW-1);

    sq_state_t     state, nstate;
    logic [CW-1:0] cnt, half;
    logic [EW-1:0] ecnt;
    logic [DW-1:0] txs, rxs;

    assign half     = (div < 2) ? CW'(2) : CW'(div);
    wire   half_end = (cnt == half - 1'b1);
    wire   gap_end  = (cnt == {half[CW-2:0], 1'b0} - 1'b1);
    wire   last     = (idx == endp);

    assign busy     = (state != SQ_IDLE);
    assign rx_we    = (state == SQ_TRAIL) && half_end;
    assign done_set = rx_we && last;
    assign rx_data  = rxs;

    always_comb begin
        unique case (state)
            SQ_IDLE:  fetch_idx = '0;
            SQ_TRAIL: fetch_idx = idx + 1'b1;
            default:  fetch_idx = idx;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SQ_IDLE;
        else        state <= nstate;
    end

    always_comb begin
        nstate = state;
        unique case (state)
            SQ_IDLE:  if (start) nstate = SQ_LEAD;
            SQ_LEAD:  if (half_end) nstate = SQ_SHIFT;
            SQ_SHIFT: if (half_end && ecnt == LAST_EDGE) nstate = SQ_TRAIL;
            SQ_TRAIL: if (half_end) nstate = last ? SQ_IDLE : (cur_cont ? SQ_LEAD : SQ_GAP);
            SQ_GAP:   if (gap_end) nstate = SQ_LEAD;
            default:  nstate = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0; ecnt <= '0; idx <= '0; txs <= '0; rxs <= '0;
            sck_ph <= 1'b0; mosi <= 1'b0; cs_act <= 1'b0;
        end else begin
            if (state == SQ_IDLE || (state == SQ_GAP ? gap_end : half_end)) cnt <= '0;
            else cnt <= cnt + 1'b1;
            unique case (state)
                SQ_IDLE: if (start) begin
                    idx <= '0; cs_act <= 1'b1;
                    txs <= cpha ? fetch_tx : fetch_tx << 1;
                    mosi <= fetch_tx[DW-1]; rxs <= '0; ecnt <= '0; sck_ph <= 1'b0;
                end
                SQ_LEAD: ;
                SQ_SHIFT: if (half_end) begin
                    sck_ph <= ~sck_ph;
                    ecnt   <= ecnt + 1'b1;
                    if (!sck_ph) begin
                        if (!cpha) rxs <= {rxs[DW-2:0], miso};
                        else begin mosi <= txs[DW-1]; txs <= txs << 1; end
                    end else begin
                        if (cpha) rxs <= {rxs[DW-2:0], miso};
                        else if (ecnt != LAST_EDGE) begin mosi <= txs[DW-1]; txs <= txs << 1; end
                    end
                end
                SQ_TRAIL: if (half_end) begin
                    if (last) cs_act <= 1'b0;
                    else begin
                        idx <= idx + 1'b1;
                        if (cur_cont) begin
                            txs <= cpha ? fetch_tx : fetch_tx << 1;
                            mosi <= fetch_tx[DW-1]; rxs <= '0; ecnt <= '0;
                        end else cs_act <= 1'b0;
                    end
                end
                SQ_GAP: if (gap_end) begin
                    cs_act <= 1'b1;
                    txs <= cpha ? fetch_tx : fetch_tx << 1;
                    mosi <= fetch_tx[DW-1]; rxs <= '0; ecnt <= '0;
                end
                default: ;
            endcase
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_IDLE) |-> (!sck_ph && !cs_act));               // R9
    AST_IDX_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SQ_IDLE) |-> (idx <= endp));                      // R3
    AST_TRAIL_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_TRAIL) |-> (!sck_ph && ecnt == '0));           // R4
    AST_GAP_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_GAP) |-> !cs_act);                             // R10
    AST_CONT_CS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == SQ_TRAIL && state == SQ_LEAD) |-> cs_act); // R10
endmodule

// File: rtl/spi_queue_master.sv
module spi_queue_master
    import spiq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [2:0]       bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic             sck_o,
    output logic             sck_oe,
    output logic             mosi_o,
    output logic             mosi_oe,
    input  logic             miso_i,
    output logic             cs_o
);
    localparam int AW = $clog2(DEPTH);

    logic [7:0]    div;
    logic          cpha, cpol, mstr, cs_idle, start, busy, done_set;
    logic          cur_cont, rx_we, sck_ph, cs_act;
    logic [AW-1:0] endp, fetch_idx, idx;
    logic [DW-1:0] fetch_tx, rx_data;

    spiq_regs #(.DEPTH(DEPTH), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .div(div), .cpha(cpha), .cpol(cpol), .mstr(mstr), .endp(endp),
        .cs_idle(cs_idle), .start(start), .busy(busy), .done_set(done_set),
        .fetch_idx(fetch_idx), .fetch_tx(fetch_tx), .cur_idx(idx),
        .cur_cont(cur_cont), .rx_we(rx_we), .rx_data(rx_data)
    );

    spiq_seq #(.DEPTH(DEPTH), .DW(DW), .DIVW(8)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .div(div), .cpha(cpha),
        .endp(endp), .fetch_tx(fetch_tx), .cur_cont(cur_cont), .miso(miso_i),
        .fetch_idx(fetch_idx), .idx(idx), .rx_we(rx_we), .rx_data(rx_data),
        .busy(busy), .done_set(done_set), .sck_ph(sck_ph), .mosi(mosi_o),
        .cs_act(cs_act)
    );

    assign sck_o   = cpol ^ sck_ph;
    assign sck_oe  = mstr;
    assign mosi_oe = mstr;
    assign cs_o    = cs_idle ^ cs_act;

    AST_CS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_o == cs_idle));                               // R9
endmodule

// File: tb/tb_spi_queue_master.sv
module tb_spi_queue_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [10:0] bus_wdata = '0;
    logic [10:0] bus_rdata;
    logic        sck_o, sck_oe, mosi_o, mosi_oe, cs_o;
    logic        miso_i;

    always #10 clk = ~clk;

    spi_queue_master dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck_o(sck_o), .sck_oe(sck_oe), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .cs_o(cs_o)
    );

    int total = 0, fails = 0;
    bit finished = 0;

    logic [7:0] txb [16];
    logic [7:0] resp [16];
    logic [7:0] cap [16];
    bit   tb_cpol = 0, tb_cpha = 0, tb_idle = 1, mon = 0;
    int   sidx = 0, scnt = 0;
    logic [7:0] sr = '0;
    logic psck = 1'b0, pcs = 1'b1;
    int   sgap = 0, min_half = 0, nsck = 0;
    int   cgap = 0, min_csgap = 0, cs_rel = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input int d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = 11'(d);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = int'(bus_rdata);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // loopback slave and timing monitors, all on the falling edge
    always_comb begin
        int bi;
        bi = (tb_cpha && sidx > 0) ? sidx - 1 : sidx;
        miso_i = (bi < 128) ? resp[bi >> 3][7 - (bi & 7)] : 1'b0;
    end

    always @(negedge clk) begin
        sgap++;
        if (sck_o != psck) begin
            if (mon && cs_o != tb_idle) begin
                if (nsck > 0 && (min_half == 0 || sgap < min_half)) min_half = sgap;
                nsck++;
                if ((psck == tb_cpol) != tb_cpha) begin
                    sr = {sr[6:0], mosi_o};
                    scnt++;
                    if ((scnt & 7) == 0) cap[(scnt >> 3) - 1] = sr;
                end else begin
                    sidx++;
                end
            end
            sgap = 0;
        end
        psck = sck_o;
        if (mon) begin
            if (cs_o == tb_idle) cgap++;
            if (pcs != tb_idle && cs_o == tb_idle) begin cs_rel++; cgap = 1; end
            if (pcs == tb_idle && cs_o != tb_idle && cs_rel > 0)
                if (min_csgap == 0 || cgap < min_csgap) min_csgap = cgap;
        end
        pcs = cs_o;
    end

    task automatic run_queue(input int n, input int md, input int divf, input int idle);
        int d, h, exp_rel, k;
        tb_cpol = md[1]; tb_cpha = md[0]; tb_idle = idle[0];
        h = (divf < 2) ? 2 : divf;
        wr(3'd0, (1 << 10) | (md << 8) | divf);
        wr(3'd2, (idle << 8) | (n - 1));
        exp_rel = 1;
        wr(3'd4, 0);
        for (int i = 0; i < n; i++) begin
            txb[i]  = 8'((i * 29 + md * 7 + 3) & 255);
            resp[i] = 8'(((i * 53 + md * 17 + n) & 255) ^ 8'hA5);
            wr(3'd5, int'(txb[i]));
        end
        wr(3'd4, 2 << 8);
        for (int i = 0; i < n; i++) begin
            wr(3'd5, (i % 3 != 2) ? 1 : 2);
            if (i < n - 1 && i % 3 == 2) exp_rel++;
        end
        wr(3'd3, 1);
        sidx = 0; scnt = 0; nsck = 0; min_half = 0; min_csgap = 0; cs_rel = 0; cgap = 0;
        for (int i = 0; i < 16; i++) cap[i] = 8'h00;
        mon = 1;
        wr(3'd1, 1);
        rd(3'd1, d);
        chk(d == 1, "R8 busy while running", d, 1);
        k = 0;
        d = 0;
        while (k < 40000 && d[0] == 1'b0) begin rd(3'd3, d); k++; end
        mon = 0;
        chk(d[0] == 1'b1, "R7 finished flag set", d, 1);
        rd(3'd1, d);
        chk(d == 0, "R8 start bit self-clears", d, 0);
        chk(cs_o == idle[0], "R9 cs idle level after queue", int'(cs_o), idle);
        chk(sck_o == md[1], "R4 sck rests at cpol", int'(sck_o), md[1]);
        chk(min_half == h, "R5 sck half period", min_half, h);
        chk(cs_rel == exp_rel, "R10 chip-select releases", cs_rel, exp_rel);
        if (exp_rel > 1)
            chk(min_csgap >= 2 * h, "R10 release width", min_csgap, 2 * h);
        for (int i = 0; i < n; i++)
            chk(cap[i] == txb[i], "R4 MOSI byte at slave", int'(cap[i]), int'(txb[i]));
        wr(3'd4, 1 << 8);
        for (int i = 0; i < n; i++) begin
            rd(3'd5, d);
            chk(d == int'(resp[i]), "R3 receive byte at index", d, int'(resp[i]));
        end
        wr(3'd3, 0);
        rd(3'd3, d);
        chk(d == 1, "R7 write 0 keeps flag", d, 1);
        wr(3'd3, 1);
        rd(3'd3, d);
        chk(d == 0, "R7 write 1 clears flag", d, 0);
    endtask

    initial begin
        int d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cs_o == 1'b1, "R1 cs after reset", int'(cs_o), 1);
        chk(sck_oe == 1'b0 && mosi_oe == 1'b0, "R1 drivers off", int'(sck_oe), 0);
        rd(3'd1, d); chk(d == 0, "R1 control", d, 0);
        rd(3'd3, d); chk(d == 0, "R1 flag", d, 0);
        rd(3'd2, d); chk(d == 256, "R1 wrap", d, 256);
        rd(3'd0, d); chk(d == 0, "R1 mode", d, 0);
        rd(3'd4, d); chk(d == 0, "R1 pointer", d, 0);
        // R2 data port stepping and wrap of the index
        wr(3'd4, 14);
        wr(3'd5, 8'h11); wr(3'd5, 8'h22); wr(3'd5, 8'h33);
        rd(3'd4, d); chk(d == 1, "R2 index after three writes wraps", d, 1);
        wr(3'd4, 14);
        rd(3'd5, d); chk(d == 8'h11, "R2 tx read idx 14", d, 8'h11);
        rd(3'd5, d); chk(d == 8'h22, "R2 tx read idx 15", d, 8'h22);
        rd(3'd5, d); chk(d == 8'h33, "R2 tx read idx 0", d, 8'h33);
        wr(3'd4, (2 << 8) | 5);
        wr(3'd5, 3); wr(3'd5, 2);
        wr(3'd4, (2 << 8) | 5);
        rd(3'd5, d); chk(d == 3, "R2 cmd read back", d, 3);
        rd(3'd5, d); chk(d == 2, "R2 cmd read back", d, 2);
        // R6 start ignored with master mode off
        wr(3'd0, 3 << 8);
        wr(3'd1, 1);
        repeat (50) @(negedge clk);
        rd(3'd1, d); chk(d == 0, "R6 no run without master", d, 0);
        rd(3'd3, d); chk(d == 0, "R6 no finish without master", d, 0);
        chk(sck_oe == 1'b0 && mosi_oe == 1'b0, "R6 drivers off", int'(sck_oe), 0);
        chk(cs_o == 1'b1, "R6 cs stays idle", int'(cs_o), 1);
        wr(3'd0, 1 << 10);
        @(negedge clk);
        chk(sck_oe == 1'b1 && mosi_oe == 1'b1, "R6 drivers on", int'(sck_oe), 1);
        // full and single entry queues in all modes
        for (int md = 0; md < 4; md++) begin
            run_queue(16, md, (md == 0) ? 0 : md + 2, (md % 2 == 0) ? 1 : 0);
            run_queue(1, md, (md == 1) ? 1 : 4, (md % 2 == 0) ? 0 : 1);
        end
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule